// File: doc/BRIEF.md
# Sticky Bit Detector

This block serves a floating-point datapath that is about to shift a wide mantissa right. Given the mantissa value and the shift amount, it reports whether any bit that the shift would push out is set. That result is the sticky (inexact) indicator used later by rounding. The block does not perform the shift, take the rounding decision or update any exception flags.

The detection builds no shift mask. It forms the word `mant | (0 - mant)` in two's complement at the full mantissa width. In that word, the lowest set bit of the mantissa and every position above it are 1, and every position below it is 0. So one bit of that word, at index `shamt - 1`, tells whether the `shamt` low bits hold any 1. The flag is offered two ways: directly from the combinational path, and as a copy captured under a valid strobe. The captured copy lets a later pipeline stage use it one cycle later.

Top module: `sticky_detect`

## Requirements
- R1: For 0 < `shamt_i` < W, `sticky_o` is 1 exactly when at least one of bits [`shamt_i`-1:0] of `mant_i` is 1.
- R2: When `shamt_i` is 0, `sticky_o` is 0 whatever `mant_i` holds.
- R3: When `shamt_i` is W or larger, `sticky_o` equals the OR of all W bits of `mant_i`.
- R4: When `mant_i` is all zeros, `sticky_o` is 0 for every `shamt_i`.
- R5: `sticky_o` is combinational: it follows `mant_i` and `shamt_i` in the same cycle, whether `valid_i` is high or not.
- R6: With the output register enabled (default), a rising clock edge with `valid_i` high loads `sticky_q_o` with that cycle's `sticky_o`, and `valid_q_o` is 1 in the following cycle.
- R7: A rising clock edge with `valid_i` low leaves `sticky_q_o` unchanged, and `valid_q_o` is 0 in the following cycle.
- R8: While `rst_n` is low, `sticky_q_o` and `valid_q_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mant_i | input | W (64) | Mantissa value to be shifted |
| shamt_i | input | NW (7) | Right-shift amount |
| valid_i | input | 1 | Strobe that loads the registered flag |
| sticky_o | output | 1 | Combinational sticky flag |
| sticky_q_o | output | 1 | Registered sticky flag |
| valid_q_o | output | 1 | Registered strobe, high when sticky_q_o was just loaded |

## Verification
`sticky_o` is due in the same cycle as its inputs. The bench drives on the falling edge and compares it against a bit-by-bit reference a nanosecond later. The registered pair is due one rising edge after the stimulus. The bench updates its own model at that edge and samples `sticky_q_o` and `valid_q_o` shortly after it, before the next falling edge changes any input. Cycles with the strobe low are mixed in, so a hold check always has a previously loaded value to compare against.

// File: rtl/sticky_pkg.sv
package sticky_pkg;
  // Captured result of one detection.
  typedef struct packed {
    logic flag;
    logic vld;
  } sticky_res_t;

  localparam int unsigned DEF_WIDTH = 64;
  localparam int unsigned DEF_SHW   = 7;
endpackage

// File: rtl/sticky_smear.sv
// Builds r | -r: ones from the lowest set bit of r upwards, zeros below it.
module sticky_smear #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] r,
  output logic [W-1:0] smear
);
  logic [W-1:0] neg_r;

  always_comb begin
    neg_r = '0 - r;
    smear = r | neg_r;
  end
endmodule

// File: rtl/sticky_pick.sv
// Picks a single bit of the smeared word according to the shift amount.
module sticky_pick #(
  parameter int unsigned W  = 64,
  parameter int unsigned NW = 7
) (
  input  logic [W-1:0]  smear,
  input  logic [NW-1:0] n,
  output logic          x
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [NW:0] W_L = (NW+1)'(W);

  logic [NW-1:0] n_m1;
  logic          n_zero;
  logic          n_full;

  always_comb begin
    n_m1   = n - 1'b1;
    n_zero = (n == '0);
    n_full = ({1'b0, n} >= W_L);
    if (n_zero)      x = 1'b0;
    else if (n_full) x = smear[W-1];
    else             x = smear[n_m1[IW-1:0]];
  end
endmodule

// File: rtl/sticky_outreg.sv
// Optional capture stage for the sticky flag.
module sticky_outreg
  import sticky_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  input  logic v_in,
  output logic x_q,
  output logic v_q
);
  generate
    if (REG_OUT) begin : g_reg
      sticky_res_t res_d, res_q;

      always_comb begin
        res_d.vld  = v_in;
        res_d.flag = v_in ? x_in : res_q.flag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
      end

      assign x_q = res_q.flag;
      assign v_q = res_q.vld;

      assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> (v_q && (x_q == $past(x_in))));
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> (!v_q && $stable(x_q)));
      assert_reset_R8: assert property (@(posedge clk)
        !rst_n |-> (!x_q && !v_q));
    end else begin : g_pass
      assign x_q = x_in;
      assign v_q = v_in;
    end
  endgenerate
endmodule

// File: rtl/sticky_detect.sv
module sticky_detect
  import sticky_pkg::*;
#(
  parameter int unsigned W       = DEF_WIDTH,
  parameter int unsigned NW      = DEF_SHW,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  mant_i,
  input  logic [NW-1:0] shamt_i,
  input  logic          valid_i,
  output logic          sticky_o,
  output logic          sticky_q_o,
  output logic          valid_q_o
);
  localparam logic [NW:0] W_L = (NW+1)'(W);

  logic [W-1:0] smear;
  logic         x_comb;

  sticky_smear #(.W(W)) u_smear (
    .r     (mant_i),
    .smear (smear)
  );

  sticky_pick #(.W(W), .NW(NW)) u_pick (
    .smear (smear),
    .n     (shamt_i),
    .x     (x_comb)
  );

  sticky_outreg #(.REG_OUT(REG_OUT)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .x_in  (x_comb),
    .v_in  (valid_i),
    .x_q   (sticky_q_o),
    .v_q   (valid_q_o)
  );

  assign sticky_o = x_comb;

  // A set flag needs some set bit in the mantissa (R1).
  assert_needs_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_o |-> (mant_i != '0));
  // Shift by one discards exactly bit 0 (R1).
  assert_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shamt_i == NW'(1)) |-> (sticky_o == mant_i[0]));
  assert_zero_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shamt_i == '0) |-> !sticky_o);
  assert_full_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, shamt_i} >= W_L) |-> (sticky_o == (mant_i != '0)));
  assert_zero_mant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mant_i == '0) |-> !sticky_o);
endmodule

// File: tb/sticky_detect_tb.sv
`timescale 1ns/1ps
module sticky_detect_tb;
  localparam int W  = 64;
  localparam int NW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  mant;
  logic [NW-1:0] shamt;
  logic          vin;
  logic          x, xq, vq;

  int checks = 0;
  int errors = 0;
  bit exp_xq;
  bit exp_vq;

  always #4 clk = ~clk;

  sticky_detect #(.W(W), .NW(NW), .REG_OUT(1'b1)) u_dut (
    .clk (clk), .rst_n (rst_n), .mant_i (mant), .shamt_i (shamt),
    .valid_i (vin), .sticky_o (x), .sticky_q_o (xq), .valid_q_o (vq)
  );

  function automatic bit ref_x(logic [W-1:0] r, int n);
    bit acc = 0;
    for (int i = 0; i < W; i++)
      if (i < n && r[i]) acc = 1;
    return acc;
  endfunction

  task automatic chk(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (mant=%h shamt=%0d)",
               req, act, exp, mant, shamt);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic [W-1:0] r, int n, bit v, string req);
    mant = r; shamt = NW'(n); vin = v;
    #1;
    chk(req, x, ref_x(r, n));
    @(posedge clk);
    if (v) exp_xq = ref_x(r, n);
    exp_vq = v;
    #1;
    chk(v ? "R6" : "R7", xq, exp_xq);
    chk(v ? "R6" : "R7", vq, exp_vq);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mant = '1; shamt = 7'd5; vin = 1'b1;
    exp_xq = 0; exp_vq = 0;
    repeat (3) @(negedge clk);
    chk("R8", xq, 1'b0);
    chk("R8", vq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero shift
    step('1, 0, 1, "R2");
    step(64'h1, 0, 1, "R2");
    // R4: zero mantissa across all amounts
    for (int n = 0; n < 128; n += 9) step('0, n, 1, "R4");
    // R3: shift at or past the width
    step(64'h8000_0000_0000_0000, 64, 1, "R3");
    step(64'h0000_0000_0000_0001, 127, 1, "R3");
    step('0, 100, 1, "R3");
    step(64'h0000_1000_0000_0000, 65, 1, "R3");
    // R1: single set bit around each boundary
    for (int p = 0; p < W; p++) begin
      step(64'h1 << p, p, 1, "R1");
      step(64'h1 << p, p + 1, p[0], "R1");
    end
    // R5: combinational path follows inputs with strobe low
    step(64'hF0, 5, 0, "R5");
    step(64'hF0, 4, 0, "R5");
    // R1: random values, mixed strobe
    for (int k = 0; k < 1500; k++) begin
      logic [W-1:0] r;
      int n;
      r = {$urandom, $urandom};
      if (k % 3 == 0) r = r & ({$urandom, $urandom} << ($urandom % 64));
      if (k % 5 == 0) r = r << ($urandom % 64);
      n = $urandom % 128;
      step(r, n, $urandom % 2, (n >= W) ? "R3" : "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule